// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Unit

This block places up to three independent down-counting timers behind one small register window. Two shared registers sit at the bottom of the window: an output-control flag and a run register with one bit per channel. Above them come fixed 12-byte slots, one per channel, at byte offsets 0x08, 0x14 and 0x20. Each channel has a reload value, a live count and a control word. Channel 2 adds a capture register that software can read and write. Each channel drives its own interrupt line.

A shared prescaler divides the clock by 4, 16, 64, 256 or 1024, and each channel picks one of these rates. A running channel counts down once per selected tick. When it ticks at zero it reloads from its reload value and sets a sticky underflow flag. The interrupt line is the flag gated by an enable bit. A parameter removes channel 2 entirely, and another removes the output-control register. Any access to something that is absent or not decoded is rejected: reads return zero, writes have no effect, and a one-cycle error pulse comes back with the response.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the run register and the output-control register read zero, and every control word reads zero. Reload and count registers read all ones, the capture register reads zero, and all interrupt outputs are low.
- R2: Offset 0x00 holds the output-control register. Only write-data bit 0 is kept, it reads back in bit 0, and it drives `out_ctl`. When `HAS_OCTL` is 0, this offset is an invalid access.
- R3: Offset 0x04 is the run register. Write-data bits 0, 1 and 2 are stored, and each one enables channel 0, 1 or 2. A read returns the stored bits in bits 2:0.
- R4: The channel slots start at 0x08, 0x14 and 0x20. Within a slot, the reload value is at +0x0, the count at +0x4 and the control word at +0x8. The capture register exists only at 0x2C, for channel 2.
- R5: Control word fields are: bits 2:0 select the tick rate, bit 5 enables the interrupt, and bit 8 is the underflow flag. A select value k from 0 to 4 divides the clock by 4^(k+1), and values 5 to 7 never tick. Writing 0 to bit 8 clears the flag, and writing 1 to bit 8 leaves it unchanged.
- R6: A running channel decrements its count on each selected tick. A tick at count zero reloads the count and sets the flag. With select 0 and reload value N, successive underflows are 4·(N+1) cycles apart.
- R7: A channel's interrupt output is high exactly when its flag and its interrupt enable are both set.
- R8: If a control write that clears the flag lands in the same cycle as an underflow of that channel, the flag stays set.
- R9: These accesses are invalid: unaligned addresses, addresses at or above 0x30, the absent channel 2 slot, and a write to the run register with bit 2 set when channel 2 is absent. An invalid access returns zero read data, changes no state, and raises `bus_err` for one cycle, in the same cycle as the read data.
- R10: A stopped channel holds its count.
- R11: Read data is registered and appears one cycle after the request. It changes only in response to reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an invalid access |
| out_ctl | output | 1 | Stored output-control bit |
| tmr_irq | output | 3 | Per-channel interrupt lines |

## Verification
Two events can fall in the same cycle: software clearing the underflow flag and the counter underflowing again. The bench runs channel 0 with reload 3 at the fastest rate. It first measures the 16-cycle interval between two underflows. Then, counting from the second interrupt rise, it times a flag-clearing control write so that it lands on the very next underflow edge. It judges the result from the interrupt line and from a control-word read on the following cycle, both of which must still show the flag set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Window layout (byte offsets); software decodes these
    localparam int unsigned OFF_OCTL    = 0;
    localparam int unsigned OFF_START   = 4;
    localparam int unsigned OFF_CH0     = 8;
    localparam int unsigned OFF_CH1     = 20;
    localparam int unsigned OFF_CH2     = 32;
    localparam int unsigned OFF_WIN_END = 48;

    // Control word fields
    localparam int unsigned SEL_W       = 3;
    localparam int unsigned CTL_IE_BIT  = 5;
    localparam int unsigned CTL_FLG_BIT = 8;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_OCTL  = 2'd1,
        TGT_START = 2'd2,
        TGT_CHAN  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        CR_RELOAD = 2'd0,
        CR_COUNT  = 2'd1,
        CR_CTRL   = 2'd2,
        CR_CAPT   = 2'd3
    } creg_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [1:0] ch;
        creg_e      creg;
    } dec_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned NSEL = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NSEL-1:0] tick
);
    localparam int unsigned PW = 2 * NSEL;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Rate k fires once every 4^(k+1) cycles
    for (genvar k = 0; k < NSEL; k++) begin : g_tick
        assign tick[k] = &cnt_q[2*k+1:0];
        if (k > 0) begin : g_nest
            // R5: a slower rate only fires together with every faster rate
            a_r5_tick_nested: assert property (@(posedge clk) disable iff (!rst_n)
                tick[k] |-> tick[k-1]);
        end
    end

endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter bit          HAS_CH2  = 1'b1,
    parameter bit          HAS_OCTL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] A_OCTL  = ADDR_W'(OFF_OCTL);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
    localparam logic [ADDR_W-1:0] A_CH0   = ADDR_W'(OFF_CH0);
    localparam logic [ADDR_W-1:0] A_CH1   = ADDR_W'(OFF_CH1);
    localparam logic [ADDR_W-1:0] A_CH2   = ADDR_W'(OFF_CH2);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(OFF_WIN_END);

    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.ch   = 2'd0;
        dec.creg = CR_RELOAD;
        if (addr[1:0] != 2'b00) begin
            dec.tgt = TGT_NONE;
        end else if (addr >= A_END) begin
            dec.tgt = TGT_NONE;
        end else if (addr >= A_CH2) begin
            if (HAS_CH2) begin
                dec.tgt  = TGT_CHAN;
                dec.ch   = 2'd2;
                dec.creg = creg_e'(2'((addr - A_CH2) >> 2));
            end
        end else if (addr >= A_CH1) begin
            dec.tgt  = TGT_CHAN;
            dec.ch   = 2'd1;
            dec.creg = creg_e'(2'((addr - A_CH1) >> 2));
        end else if (addr >= A_CH0) begin
            dec.tgt  = TGT_CHAN;
            dec.ch   = 2'd0;
            dec.creg = creg_e'(2'((addr - A_CH0) >> 2));
        end else if (addr == A_START) begin
            dec.tgt = TGT_START;
        end else if (addr == A_OCTL && HAS_OCTL) begin
            dec.tgt = TGT_OCTL;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned NSEL     = 5,
    parameter bit          HAS_CAPT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [NSEL-1:0] tick_vec,
    input  logic            wr_reload,
    input  logic            wr_count,
    input  logic            wr_ctrl,
    input  logic            wr_capt,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   reload_rd,
    output logic [DW-1:0]   count_rd,
    output logic [DW-1:0]   ctrl_rd,
    output logic [DW-1:0]   capt_rd,
    output logic            irq
);
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NSEL);

    typedef struct packed {
        logic [DW-1:0]    reload;
        logic [DW-1:0]    count;
        logic [SEL_W-1:0] sel;
        logic             ie;
        logic             flag;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   tick_sel;
    logic   step;
    logic   underflow;

    always_comb begin
        tick_sel  = 1'b0;
        for (int k = 0; k < NSEL; k++) begin
            if (st_q.sel == SEL_W'(k)) tick_sel = tick_vec[k];
        end
        if (st_q.sel >= SEL_LIMIT) tick_sel = 1'b0;
        step      = run & tick_sel;
        underflow = step && (st_q.count == '0);
    end

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.count = underflow ? st_q.reload : st_q.count - DW'(1);
        end
        if (underflow) st_d.flag = 1'b1;
        if (wr_reload) st_d.reload = wdata;
        if (wr_count)  st_d.count  = wdata;
        if (wr_ctrl) begin
            st_d.sel = wdata[SEL_W-1:0];
            st_d.ie  = wdata[CTL_IE_BIT];
            // a fresh underflow outranks a clearing write
            if (!wdata[CTL_FLG_BIT] && !underflow) st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.reload <= '1;
            st_q.count  <= '1;
            st_q.sel    <= '0;
            st_q.ie     <= 1'b0;
            st_q.flag   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_rd = st_q.reload;
    assign count_rd  = st_q.count;
    assign ctrl_rd   = {{(DW-9){1'b0}}, st_q.flag, 2'b00, st_q.ie, 2'b00, st_q.sel};
    assign irq       = st_q.flag & st_q.ie;

    if (HAS_CAPT) begin : g_capt
        logic [DW-1:0] capt_d, capt_q;
        always_comb begin
            capt_d = capt_q;
            if (wr_capt) capt_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) capt_q <= '0;
            else        capt_q <= capt_d;
        end
        assign capt_rd = capt_q;
    end else begin : g_no_capt
        logic unused_capt;
        assign unused_capt = wr_capt;
        assign capt_rd     = '0;
    end

    // R6: an underflow reloads the count from the value held before it
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !wr_count) |=> (st_q.count == $past(st_q.reload)));

    // R8: the flag is set after any underflow, whatever software wrote
    a_r8_flag_wins: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> st_q.flag);

    // R5: only a control write can drop the flag
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !wr_ctrl) |=> st_q.flag);

    // R10: a stopped channel keeps its count
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(st_q.count));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DW       = 32,
    parameter int unsigned NSEL     = 5,
    parameter bit          HAS_CH2  = 1'b1,
    parameter bit          HAS_OCTL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    output logic              out_ctl,
    output logic [2:0]        tmr_irq
);
    localparam int unsigned NCH = 3;

    typedef struct packed {
        logic           octl;
        logic [NCH-1:0] start;
        logic [DW-1:0]  rdata;
        logic           err;
    } top_st_t;

    top_st_t         st_d, st_q;
    dec_t            dec;
    logic [NSEL-1:0] tick;
    logic            bad;
    logic            wr_ok;
    logic [NCH-1:0]  wr_reload, wr_count, wr_ctrl, wr_capt;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   ch_reload [NCH];
    logic [DW-1:0]   ch_count  [NCH];
    logic [DW-1:0]   ch_ctrl   [NCH];
    logic [DW-1:0]   ch_capt   [NCH];

    tmr_decode #(
        .ADDR_W   (ADDR_W),
        .HAS_CH2  (HAS_CH2),
        .HAS_OCTL (HAS_OCTL)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    tmr_prescaler #(.NSEL(NSEL)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        bad = bus_en && ((dec.tgt == TGT_NONE) ||
              ((dec.tgt == TGT_START) && bus_we && !HAS_CH2 && bus_wdata[2]));
        wr_ok = bus_en && bus_we && !bad;
    end

    always_comb begin
        rd_mux = '0;
        case (dec.tgt)
            TGT_OCTL:  rd_mux = {{(DW-1){1'b0}}, st_q.octl};
            TGT_START: rd_mux = {{(DW-NCH){1'b0}}, st_q.start};
            TGT_CHAN: begin
                for (int i = 0; i < NCH; i++) begin
                    if (dec.ch == 2'(i)) begin
                        case (dec.creg)
                            CR_RELOAD: rd_mux = ch_reload[i];
                            CR_COUNT:  rd_mux = ch_count[i];
                            CR_CTRL:   rd_mux = ch_ctrl[i];
                            default:   rd_mux = ch_capt[i];
                        endcase
                    end
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.err  = bad;
        wr_reload = '0;
        wr_count  = '0;
        wr_ctrl   = '0;
        wr_capt   = '0;
        if (wr_ok) begin
            case (dec.tgt)
                TGT_OCTL:  st_d.octl  = bus_wdata[0];
                TGT_START: st_d.start = bus_wdata[NCH-1:0];
                TGT_CHAN: begin
                    case (dec.creg)
                        CR_RELOAD: wr_reload[dec.ch] = 1'b1;
                        CR_COUNT:  wr_count[dec.ch]  = 1'b1;
                        CR_CTRL:   wr_ctrl[dec.ch]   = 1'b1;
                        default:   wr_capt[dec.ch]   = (dec.ch == 2'd2);
                    endcase
                end
                default: ;
            endcase
        end
        if (bus_en && !bus_we) st_d.rdata = bad ? '0 : rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i < 2 || HAS_CH2) begin : g_on
            tmr_channel #(
                .DW       (DW),
                .NSEL     (NSEL),
                .HAS_CAPT (i == 2)
            ) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (st_q.start[i]),
                .tick_vec  (tick),
                .wr_reload (wr_reload[i]),
                .wr_count  (wr_count[i]),
                .wr_ctrl   (wr_ctrl[i]),
                .wr_capt   (wr_capt[i]),
                .wdata     (bus_wdata),
                .reload_rd (ch_reload[i]),
                .count_rd  (ch_count[i]),
                .ctrl_rd   (ch_ctrl[i]),
                .capt_rd   (ch_capt[i]),
                .irq       (tmr_irq[i])
            );
        end else begin : g_off
            logic unused_off;
            assign unused_off   = ^{wr_reload[i], wr_count[i], wr_ctrl[i],
                                    wr_capt[i], st_q.start[i]};
            assign ch_reload[i] = '0;
            assign ch_count[i]  = '0;
            assign ch_ctrl[i]   = '0;
            assign ch_capt[i]   = '0;
            assign tmr_irq[i]   = 1'b0;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
    assign out_ctl   = st_q.octl;

    // R9: an error response always answers a request of the cycle before
    a_r9_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_en));

    // R9: a rejected write leaves the shared registers untouched
    a_r9_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bad) |=> ($stable(st_q.start) && $stable(st_q.octl)));

    // R3: without channel 2 its run bit can never become set
    a_r3_no_third_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CH2) |-> (st_q.start[2] == 1'b0));

    // R11: read data moves only in answer to a read
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_en && !bus_we) |-> $stable(bus_rdata));

endmodule

// File: tb/tb_tmr_unit.sv
`timescale 1ns/1ps
module tb_tmr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_a = 1'b0, en_b = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        err_a, err_b, octl_a, octl_b;
    logic [2:0]  irq_a, irq_b;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tmr_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_en(en_a), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .bus_err(err_a),
        .out_ctl(octl_a), .tmr_irq(irq_a)
    );

    tmr_unit #(.HAS_CH2(1'b0), .HAS_OCTL(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_en(en_b), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .bus_err(err_b),
        .out_ctl(octl_b), .tmr_irq(irq_b)
    );

    typedef struct packed {
        logic        w;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd2},  // R2
        '{1'b0, 8'h00, 32'h0,         32'h1,          1'b0, 8'd2},  // R2 only bit 0 kept
        '{1'b1, 8'h00, 32'hFFFF_FFFE, 32'h0,          1'b0, 8'd2},
        '{1'b0, 8'h00, 32'h0,         32'h0,          1'b0, 8'd2},
        '{1'b1, 8'h04, 32'h0000_0001, 32'h0,          1'b0, 8'd3},  // R3
        '{1'b0, 8'h04, 32'h0,         32'h1,          1'b0, 8'd3},
        '{1'b1, 8'h04, 32'h0,         32'h0,          1'b0, 8'd3},
        '{1'b0, 8'h04, 32'h0,         32'h0,          1'b0, 8'd3},
        '{1'b1, 8'h08, 32'h0000_1234, 32'h0,          1'b0, 8'd4},  // R4
        '{1'b0, 8'h08, 32'h0,         32'h0000_1234,  1'b0, 8'd4},
        '{1'b1, 8'h0C, 32'h0000_0055, 32'h0,          1'b0, 8'd4},
        '{1'b0, 8'h0C, 32'h0,         32'h0000_0055,  1'b0, 8'd4},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd5},  // R5
        '{1'b0, 8'h10, 32'h0,         32'h0000_0027,  1'b0, 8'd5},
        '{1'b1, 8'h14, 32'hA5A5_A5A5, 32'h0,          1'b0, 8'd4},
        '{1'b0, 8'h14, 32'h0,         32'hA5A5_A5A5,  1'b0, 8'd4},
        '{1'b0, 8'h08, 32'h0,         32'h0000_1234,  1'b0, 8'd4},
        '{1'b1, 8'h2C, 32'h0BAD_F00D, 32'h0,          1'b0, 8'd4},
        '{1'b0, 8'h2C, 32'h0,         32'h0BAD_F00D,  1'b0, 8'd4},
        '{1'b0, 8'h24, 32'h0,         32'hFFFF_FFFF,  1'b0, 8'd1},  // R1
        '{1'b0, 8'h30, 32'h0,         32'h0,          1'b1, 8'd9},  // R9
        '{1'b1, 8'h30, 32'h1,         32'h0,          1'b1, 8'd9},
        '{1'b0, 8'h02, 32'h0,         32'h0,          1'b1, 8'd9},
        '{1'b0, 8'h20, 32'h0,         32'hFFFF_FFFF,  1'b0, 8'd1},
        '{1'b0, 8'h18, 32'h0,         32'hFFFF_FFFF,  1'b0, 8'd1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the response
    task automatic acc(input bit on_b, input bit w, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output logic er);
        we = w; addr = a; wdata = d;
        if (on_b) en_b = 1'b1; else en_a = 1'b1;
        @(negedge clk);
        rd = on_b ? rdata_b : rdata_a;
        er = on_b ? err_b : err_a;
        en_a = 1'b0; en_b = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd, c1;
        logic er;
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq_a == 3'b000 && octl_a == 1'b0, "R1 irq/outctl", {28'd0, octl_a, irq_a}, 32'h0);
        acc(0, 0, 8'h04, 0, rd, er);  chk(rd == 0 && !er, "R1 run reg", rd, 32'h0);
        acc(0, 0, 8'h10, 0, rd, er);  chk(rd == 0, "R1 ctrl", rd, 32'h0);
        acc(0, 0, 8'h2C, 0, rd, er);  chk(rd == 0, "R1 capture", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(0, VECS[i].w, VECS[i].a, VECS[i].d, rd, er);
            chk(er == VECS[i].exp_err, $sformatf("R%0d err vec%0d", VECS[i].req, i),
                {31'd0, er}, {31'd0, VECS[i].exp_err});
            if (!VECS[i].w)
                chk(rd == VECS[i].exp, $sformatf("R%0d data vec%0d", VECS[i].req, i),
                    rd, VECS[i].exp);
        end

        // R2 port follows stored bit
        acc(0, 1, 8'h00, 32'h1, rd, er);
        chk(octl_a == 1'b1, "R2 out_ctl", {31'd0, octl_a}, 32'h1);
        // R11 a write leaves read data alone (last read returned ffffffff)
        chk(rdata_a == 32'hFFFF_FFFF, "R11 rdata after write", rdata_a, 32'hFFFF_FFFF);
        acc(0, 1, 8'h00, 32'h0, rd, er);

        // R5 select 7 never ticks: ch0 ctrl=0x27, count 0x55
        acc(0, 1, 8'h04, 32'h1, rd, er);
        repeat (40) @(negedge clk);
        acc(0, 0, 8'h0C, 0, rd, er);
        chk(rd == 32'h55, "R5 reserved rate holds", rd, 32'h55);
        acc(0, 1, 8'h04, 32'h0, rd, er);

        // R6 period with reload 3, rate 0, interrupt enabled
        acc(0, 1, 8'h08, 32'd3, rd, er);
        acc(0, 1, 8'h0C, 32'd3, rd, er);
        acc(0, 1, 8'h10, 32'h20, rd, er);
        acc(0, 1, 8'h04, 32'h1, rd, er);
        cnt = 0;
        while (!irq_a[0] && cnt < 200) begin @(negedge clk); cnt++; end
        chk(irq_a[0] == 1'b1, "R7 irq rises", {31'd0, irq_a[0]}, 32'h1);
        acc(0, 1, 8'h10, 32'h20, rd, er);          // clear flag
        chk(irq_a[0] == 1'b0, "R5 flag cleared", {31'd0, irq_a[0]}, 32'h0);
        cnt = 1;
        while (!irq_a[0] && cnt < 200) begin @(negedge clk); cnt++; end
        chk(cnt == 16, "R6 underflow period", cnt, 32'd16);

        // R8 clearing write lands on the next underflow edge
        repeat (15) @(negedge clk);
        acc(0, 1, 8'h10, 32'h20, rd, er);
        chk(irq_a[0] == 1'b1, "R8 irq kept", {31'd0, irq_a[0]}, 32'h1);
        acc(0, 0, 8'h10, 0, rd, er);
        chk(rd == 32'h120, "R8 flag kept", rd, 32'h120);

        // R7 enable low masks the line while the flag collects underflows
        acc(0, 1, 8'h10, 32'h0, rd, er);
        chk(irq_a[0] == 1'b0, "R7 masked", {31'd0, irq_a[0]}, 32'h0);
        repeat (40) @(negedge clk);
        chk(irq_a[0] == 1'b0, "R7 still masked", {31'd0, irq_a[0]}, 32'h0);
        acc(0, 0, 8'h10, 0, rd, er);
        chk(rd == 32'h100, "R7 flag set under mask", rd, 32'h100);
        chk(irq_a[1] == 1'b0, "R3 idle channel quiet", {31'd0, irq_a[1]}, 32'h0);

        // R10 stopped channel holds
        acc(0, 1, 8'h04, 32'h0, rd, er);
        acc(0, 0, 8'h0C, 0, c1, er);
        repeat (30) @(negedge clk);
        acc(0, 0, 8'h0C, 0, rd, er);
        chk(rd == c1, "R10 count held", rd, c1);

        // Two-channel configuration, no output-control register
        acc(1, 1, 8'h04, 32'h4, rd, er);
        chk(er == 1'b1, "R9 run bit 2 rejected", {31'd0, er}, 32'h1);
        acc(1, 0, 8'h04, 0, rd, er);
        chk(rd == 32'h0, "R9 rejected write ignored", rd, 32'h0);
        acc(1, 1, 8'h04, 32'h3, rd, er);
        chk(er == 1'b0, "R3 run bits 1:0 accepted", {31'd0, er}, 32'h0);
        acc(1, 0, 8'h04, 0, rd, er);
        chk(rd == 32'h3, "R3 readback", rd, 32'h3);
        acc(1, 0, 8'h20, 0, rd, er);
        chk(er == 1'b1 && rd == 0, "R9 absent slot", rd, 32'h0);
        acc(1, 0, 8'h00, 0, rd, er);
        chk(er == 1'b1 && rd == 0, "R2 absent outctl", {31'd0, er}, 32'h1);
        @(negedge clk);
        chk(err_b == 1'b0, "R9 single pulse", {31'd0, err_b}, 32'h0);
        chk(irq_b[2] == 1'b0, "R4 no third irq", {31'd0, irq_b[2]}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule